// File: doc/BRIEF.md
# Second-Level Cache Tag Strobe Sequencer

This block produces the control strobes for an external tag RAM that serves a second-level cache beside a processor bus. It opens a hit-sampling window a programmable number of clocks after each transfer start and closes it when the address phase ends. It also runs the tag read window of a copy-back (castout). After a bus turnaround clock it issues a tag write pulse. It drives the tag valid line, with selectable polarity, around every tag write.

A copy-back request starts a read window in which the tag RAM drives its indexed entry onto the address bus. The window is followed by one idle clock and a single-clock write strobe. A plain tag-update request skips the read and issues the write strobe at once. The valid value to be written is sampled from `upd_valid` when either request is accepted. The tag valid line holds that value through the write strobe and for one clock after it. Static configuration inputs set four things: the hit delay, the read window length, the valid polarity, and whether the valid line is released during tag reads.

Top module: `l2tag_ctrl`

## Requirements
- R1: While `rst_n` is low, `tag_oe_n` and `tag_we_n` are high, `hit_sample` is low, `tag_valid_oe` is high, and `tag_valid` shows the invalid level.
- R2: A `xfer_start` sampled at edge k raises `hit_sample` after edge k+`cfg_hit_dly`+1. The code 0..3 means 1..4 clocks.
- R3: An `addr_phase_end` sampled high, with no `xfer_start` in the same cycle, leaves `hit_sample` low after that edge. This applies both while waiting and while the window is open.
- R4: A `xfer_start` during a pending or open hit window closes the window and restarts the delay count from that edge.
- R5: A `castout_req` accepted at edge k holds `tag_oe_n` low after edges k through k+L-1. L is 3 when `cfg_toe_3clk`=1 and 2 when it is 0.
- R6: After the read window of a copy-back there is exactly one clock with both strobes high. `tag_we_n` is then low for exactly the one clock after edge k+L+1, and the two strobes are never low together.
- R7: A `upd_req` accepted at edge k drives `tag_we_n` low for the single clock after edge k. `castout_req` wins if both are present in the same cycle.
- R8: `tag_valid` equals the captured valid value when `cfg_valid_hi`=1 and its inverse when `cfg_valid_hi`=0.
- R9: `tag_valid` keeps the captured value while `tag_we_n` is low and for one clock after it rises.
- R10: `tag_valid_oe` is low only while `tag_oe_n` is low and both `cfg_fast_co` and `cfg_hold` are 0. Otherwise it stays high.
- R11: While a copy-back or a write pulse with its hold clock is in progress, `upd_req` and `castout_req` have no effect on the strobes or on `tag_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Transfer-start pulse |
| addr_phase_end | input | 1 | Address phase ends this cycle |
| castout_req | input | 1 | Copy-back request (read tag, then write) |
| upd_req | input | 1 | Tag update request (write only) |
| upd_valid | input | 1 | Valid value for the tag write |
| cfg_hit_dly | input | 2 | Hit delay code, clocks minus one |
| cfg_toe_3clk | input | 1 | Read window of 3 clocks (else 2) |
| cfg_valid_hi | input | 1 | Tag valid is active high |
| cfg_fast_co | input | 1 | Keep tag valid driven during reads |
| cfg_hold | input | 1 | Keep tag valid driven during reads |
| hit_sample | output | 1 | Hit input may be sampled |
| tag_oe_n | output | 1 | Tag RAM output enable, active low |
| tag_valid | output | 1 | Tag valid status line |
| tag_valid_oe | output | 1 | Output enable of the tag valid driver |
| tag_we_n | output | 1 | Tag write enable, active low |

## Verification
Each result is registered one edge after its cause. `hit_sample` rises after edge k+code+1 of a start sampled at edge k and falls on the edge that samples the end of the address phase. For a copy-back, the read enable covers edges k..k+L-1, the turnaround falls at k+L, and the write strobe comes at k+L+1 with its hold at k+L+2. Inputs change just after a falling edge and outputs are read at the next falling edge, so each check names the exact edge offset it expects.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
  typedef enum logic [1:0] {
    HT_IDLE  = 2'd0,
    HT_COUNT = 2'd1,
    HT_OPEN  = 2'd2
  } hit_state_e;

  typedef enum logic [2:0] {
    CB_IDLE  = 3'd0,
    CB_READ  = 3'd1,
    CB_GAP   = 3'd2,
    CB_WRITE = 3'd3,
    CB_HOLD  = 3'd4
  } cb_state_e;
endpackage

// File: rtl/l2tag_hit_timer.sv
module l2tag_hit_timer
  import l2tag_pkg::*;
#(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             phase_end,
  input  logic [DLY_W-1:0] dly_code,
  output logic             window
);
  hit_state_e       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (start) begin
      st_d  = HT_COUNT;
      cnt_d = dly_code;
    end else begin
      case (st_q)
        HT_COUNT: begin
          if (phase_end)           st_d = HT_IDLE;
          else if (cnt_q == '0)    st_d = HT_OPEN;
          else                     cnt_d = cnt_q - 1'b1;
        end
        HT_OPEN: if (phase_end)    st_d = HT_IDLE;
        default:                   st_d = HT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HT_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign window = (st_q == HT_OPEN);
endmodule

// File: rtl/l2tag_cb_fsm.sv
module l2tag_cb_fsm
  import l2tag_pkg::*;
#(
  parameter int RD_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic castout_req,
  input  logic upd_req,
  input  logic rd_3clk,
  output logic accept,
  output logic rd_active,
  output logic wr_active,
  output logic hold_active
);
  localparam logic [RD_W-1:0] RD_LONG  = RD_W'(2);
  localparam logic [RD_W-1:0] RD_SHORT = RD_W'(1);

  cb_state_e       st_q, st_d;
  logic [RD_W-1:0] rc_q, rc_d;
  logic            rc_en;

  always_comb begin
    st_d   = st_q;
    rc_d   = rc_q;
    rc_en  = 1'b0;
    accept = 1'b0;
    case (st_q)
      CB_IDLE: begin
        if (castout_req) begin
          st_d   = CB_READ;
          rc_d   = rd_3clk ? RD_LONG : RD_SHORT;
          rc_en  = 1'b1;
          accept = 1'b1;
        end else if (upd_req) begin
          st_d   = CB_WRITE;
          accept = 1'b1;
        end
      end
      CB_READ: begin
        if (rc_q == '0) st_d = CB_GAP;
        else begin
          rc_d  = rc_q - 1'b1;
          rc_en = 1'b1;
        end
      end
      CB_GAP:   st_d = CB_WRITE;
      CB_WRITE: st_d = CB_HOLD;
      default:  st_d = CB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CB_IDLE;
      rc_q <= '0;
    end else begin
      st_q <= st_d;
      if (rc_en) rc_q <= rc_d;
    end
  end

  assign rd_active   = (st_q == CB_READ);
  assign wr_active   = (st_q == CB_WRITE);
  assign hold_active = (st_q == CB_HOLD);
endmodule

// File: rtl/l2tag_valid_drv.sv
module l2tag_valid_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic valid_in,
  input  logic rd_active,
  input  logic act_high,
  input  logic keep_fast,
  input  logic keep_hold,
  output logic valid_pin,
  output logic valid_oe
);
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= 1'b0;
    else if (load) lat_q <= valid_in;
  end

  assign valid_pin = act_high ? lat_q : ~lat_q;
  assign valid_oe  = ~(rd_active & ~keep_fast & ~keep_hold);
endmodule

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl
  import l2tag_pkg::*;
#(
  parameter int DLY_W   = 2,
  parameter int RD_W    = 2,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             addr_phase_end,
  input  logic             castout_req,
  input  logic             upd_req,
  input  logic             upd_valid,
  input  logic [DLY_W-1:0] cfg_hit_dly,
  input  logic             cfg_toe_3clk,
  input  logic             cfg_valid_hi,
  input  logic             cfg_fast_co,
  input  logic             cfg_hold,
  output logic             hit_sample,
  output logic             tag_oe_n,
  output logic             tag_valid,
  output logic             tag_valid_oe,
  output logic             tag_we_n
);
  logic [SYNC_ST-1:0] rst_pipe_q;
  logic               rst_int_n;
  logic               accept, rd_active, wr_active, hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_ST-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_ST-1];

  l2tag_hit_timer #(.DLY_W(DLY_W)) hit_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (xfer_start),
    .phase_end (addr_phase_end),
    .dly_code  (cfg_hit_dly),
    .window    (hit_sample)
  );

  l2tag_cb_fsm #(.RD_W(RD_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .castout_req (castout_req),
    .upd_req     (upd_req),
    .rd_3clk     (cfg_toe_3clk),
    .accept      (accept),
    .rd_active   (rd_active),
    .wr_active   (wr_active),
    .hold_active (hold_active)
  );

  l2tag_valid_drv vld_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (accept),
    .valid_in  (upd_valid),
    .rd_active (rd_active),
    .act_high  (cfg_valid_hi),
    .keep_fast (cfg_fast_co),
    .keep_hold (cfg_hold),
    .valid_pin (tag_valid),
    .valid_oe  (tag_valid_oe)
  );

  assign tag_oe_n = ~rd_active;
  assign tag_we_n = ~wr_active;
endmodule

// File: rtl/l2tag_ctrl_chk.sv
module l2tag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_start,
  input logic addr_phase_end,
  input logic cfg_valid_hi,
  input logic cfg_fast_co,
  input logic cfg_hold,
  input logic hit_sample,
  input logic tag_oe_n,
  input logic tag_valid,
  input logic tag_valid_oe,
  input logic tag_we_n
);
  AST_RST_IDLE: assert property (@(posedge clk)
    !rst_n |-> (tag_oe_n && tag_we_n && !hit_sample && tag_valid_oe)); // R1

  AST_HIT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase_end && !xfer_start) |=> !hit_sample); // R3

  AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !hit_sample); // R4

  AST_TOE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_oe_n) |-> $past(!tag_oe_n, 2)); // R5

  AST_TOE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_oe_n && $past(!tag_oe_n) && $past(!tag_oe_n, 2)) |=> tag_oe_n); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!tag_oe_n && !tag_we_n)); // R6

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_oe_n) |-> tag_we_n); // R6

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_we_n |=> tag_we_n); // R7

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tag_we_n) && $stable(cfg_valid_hi)) |-> $stable(tag_valid)); // R9

  AST_VOE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_valid_oe |-> (!tag_oe_n && !cfg_fast_co && !cfg_hold)); // R10
endmodule

bind l2tag_ctrl l2tag_ctrl_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .xfer_start     (xfer_start),
  .addr_phase_end (addr_phase_end),
  .cfg_valid_hi   (cfg_valid_hi),
  .cfg_fast_co    (cfg_fast_co),
  .cfg_hold       (cfg_hold),
  .hit_sample     (hit_sample),
  .tag_oe_n       (tag_oe_n),
  .tag_valid      (tag_valid),
  .tag_valid_oe   (tag_valid_oe),
  .tag_we_n       (tag_we_n)
);

// File: tb/l2tag_ctrl_tb.sv
module l2tag_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       xfer_start, addr_phase_end, castout_req, upd_req, upd_valid;
  logic [1:0] cfg_hit_dly;
  logic       cfg_toe_3clk, cfg_valid_hi, cfg_fast_co, cfg_hold;
  logic       hit_sample, tag_oe_n, tag_valid, tag_valid_oe, tag_we_n;

  int n_chk;
  int n_fail;

  l2tag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .addr_phase_end(addr_phase_end), .castout_req(castout_req),
    .upd_req(upd_req), .upd_valid(upd_valid), .cfg_hit_dly(cfg_hit_dly),
    .cfg_toe_3clk(cfg_toe_3clk), .cfg_valid_hi(cfg_valid_hi),
    .cfg_fast_co(cfg_fast_co), .cfg_hold(cfg_hold),
    .hit_sample(hit_sample), .tag_oe_n(tag_oe_n), .tag_valid(tag_valid),
    .tag_valid_oe(tag_valid_oe), .tag_we_n(tag_we_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    xfer_start = 0; addr_phase_end = 0; castout_req = 0;
    upd_req = 0; upd_valid = 0;
  endtask

  // R1
  task automatic t_reset();
    rst_n = 0;
    clear_inputs();
    cfg_hit_dly = 0; cfg_toe_3clk = 0; cfg_valid_hi = 1;
    cfg_fast_co = 0; cfg_hold = 0;
    repeat (3) tick();
    check("R1", "tag_oe_n", tag_oe_n, 1'b1);
    check("R1", "tag_we_n", tag_we_n, 1'b1);
    check("R1", "hit_sample", hit_sample, 1'b0);
    check("R1", "tag_valid_oe", tag_valid_oe, 1'b1);
    check("R1", "tag_valid", tag_valid, 1'b0);
    rst_n = 1;
    repeat (4) tick();
  endtask

  // R2 and R3
  task automatic t_hit(input logic [1:0] code);
    int n;
    n = int'(code) + 1;
    cfg_hit_dly = code;
    xfer_start = 1; tick(); xfer_start = 0;
    check("R2", "hit at start edge", hit_sample, 1'b0);
    for (int j = 1; j <= n; j++) begin
      tick();
      check("R2", $sformatf("hit code %0d edge +%0d", code, j),
            hit_sample, (j >= n));
    end
    tick();
    check("R2", "hit held open", hit_sample, 1'b1);
    addr_phase_end = 1; tick(); addr_phase_end = 0;
    check("R3", "hit closed by phase end", hit_sample, 1'b0);
    tick();
  endtask

  // R3 early end and R4 restart
  task automatic t_hit_restart();
    cfg_hit_dly = 2'd3;
    xfer_start = 1; tick(); xfer_start = 0;
    tick(); tick();
    xfer_start = 1; tick(); xfer_start = 0;
    for (int j = 1; j <= 4; j++) begin
      tick();
      check("R4", $sformatf("restart edge +%0d", j), hit_sample, (j >= 4));
    end
    xfer_start = 1; tick(); xfer_start = 0;
    check("R4", "start during open window closes it", hit_sample, 1'b0);
    addr_phase_end = 1; tick(); addr_phase_end = 0;
    repeat (5) begin
      tick();
      check("R3", "phase end while pending", hit_sample, 1'b0);
    end
  endtask

  // R5, R6, R8, R9, R10, R11
  task automatic t_castout(input logic three, input logic fast, input logic hold,
                           input logic pol, input logic v);
    int L;
    logic lvl;
    L = three ? 3 : 2;
    lvl = pol ? v : ~v;
    cfg_toe_3clk = three; cfg_fast_co = fast; cfg_hold = hold; cfg_valid_hi = pol;
    castout_req = 1; upd_valid = v; tick();
    castout_req = 0; upd_valid = 0;
    upd_req = 1;
    for (int j = 0; j <= L + 3; j++) begin
      if (j > 0) tick();
      if (j == L + 2) upd_req = 0;
      check("R5", $sformatf("toe L%0d edge +%0d", L, j), tag_oe_n, !(j < L));
      check("R6", $sformatf("we L%0d edge +%0d", L, j), tag_we_n, !(j == L + 1));
      check("R10", $sformatf("voe f%0d h%0d edge +%0d", fast, hold, j),
            tag_valid_oe, !((j < L) && !fast && !hold));
      if (j >= L + 1 && j <= L + 2)
        check("R9", $sformatf("valid edge +%0d", j), tag_valid, lvl);
    end
    check("R11", "update during copy-back ignored, valid kept", tag_valid, lvl);
    tick();
  endtask

  // R7, R8, R9, R11
  task automatic t_update(input logic pol, input logic v);
    logic lvl;
    lvl = pol ? v : ~v;
    cfg_valid_hi = pol;
    upd_req = 1; upd_valid = v; tick();
    upd_valid = ~v; castout_req = 1;
    check("R7", "we low after accept", tag_we_n, 1'b0);
    check("R8", $sformatf("valid pol %0d", pol), tag_valid, lvl);
    tick();
    check("R7", "we single clock", tag_we_n, 1'b1);
    check("R9", "valid held after we", tag_valid, lvl);
    tick();
    upd_req = 0; castout_req = 0;
    check("R11", "no second pulse", tag_we_n, 1'b1);
    check("R11", "no read window", tag_oe_n, 1'b1);
    check("R11", "valid not reloaded", tag_valid, lvl);
    tick();
    check("R11", "still idle", tag_we_n, 1'b1);
  endtask

  // R7 priority
  task automatic t_both();
    cfg_toe_3clk = 0;
    castout_req = 1; upd_req = 1; upd_valid = 1; tick();
    castout_req = 0; upd_req = 0;
    check("R7", "castout wins: toe", tag_oe_n, 1'b0);
    check("R7", "castout wins: no we", tag_we_n, 1'b1);
    repeat (6) tick();
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    for (int c = 0; c < 4; c++) t_hit(2'(c));
    t_hit_restart();
    t_castout(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    t_castout(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    t_castout(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    t_castout(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    t_update(1'b1, 1'b1);
    t_update(1'b0, 1'b1);
    t_update(1'b1, 1'b0);
    t_update(1'b0, 1'b0);
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule